// File: doc/BRIEF.md
# Guard-bit DSP barrel shifter

This block shifts a 40-bit fixed-point operand (a 32-bit base word with 8 guard bits above it) in a single combinational pass and captures five status flags in a register. It sits in a DSP datapath behind the register-file read ports. It offers two operations, arithmetic and logical. The shift amount is a signed 7-bit value. The sign of that value sets the direction: zero or positive shifts left, negative shifts right by the magnitude.

The amount comes from the immediate input when `use_imm` is set. Otherwise it comes from bits 22..16 of the second source word, and every other bit of that word plays no part. A source register without guard bits is sign-extended from its bit 31 before the shift. A destination without guard bits takes `res_trunc`, which is the low 32 bits of the result. The flags are written on the clock edge that follows any cycle with `valid` high.

Top module: `gbit_shifter`

## Requirements
- R1: With `use_imm`=1 the amount is `imm`. With `use_imm`=0 it is `src_b[22:16]`, read as two's complement, and every other bit of `src_b` has no effect.
- R2: An amount of zero or more shifts left by that many places. A negative amount shifts right by its magnitude.
- R3: Arithmetic (`op_logical`=0) acts on all 40 bits. A left shift fills with zeros. A right shift fills with copies of bit 39. Bits shifted past either end are lost.
- R4: With `src_guard`=0, bits 39..32 of `src_a` are ignored and are replaced by copies of `src_a[31]` before the shift.
- R5: Logical (`op_logical`=1) shifts only bits 31..16 and fills with zeros in both directions. Result bits 39..32 and 15..0 are zero.
- R6: Amounts beyond the legal range are clamped to the nearest limit. The limit is ±32 for arithmetic and ±16 for logical.
- R7: `res_trunc` always equals bits 31..0 of `res_full`.
- R8: One cycle after `valid`, `flag_z` = (result == 0), `flag_n` = result bit 39, and `flag_gt` = !Z && !N.
- R9: `flag_v` is set after an arithmetic left shift whose result bit 39 differs from bit 39 of the (extended) operand. It is always 0 after a logical shift.
- R10: `flag_dc` holds the last bit shifted out. It is 0 when the clamped amount is zero.
- R11: Reset clears all flags to 0. While `valid` is low the flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Operation issued this cycle; flags update |
| op_logical | input | 1 | 1 = logical shift, 0 = arithmetic |
| use_imm | input | 1 | 1 = amount from `imm`, 0 = from `src_b[22:16]` |
| imm | input | 7 | Signed immediate amount |
| src_a | input | 40 | Operand to shift |
| src_guard | input | 1 | 1 = `src_a` carries valid guard bits |
| src_b | input | 32 | Second source word holding the amount field |
| res_full | output | 40 | Shifted 40-bit result |
| res_trunc | output | 32 | Low 32 bits of the result |
| flag_gt | output | 1 | Greater-than-zero flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_dc | output | 1 | Last bit shifted out |

## Verification
The result path holds no state, so a wrong amount decode, clamp or fill bit shows on `res_full` in the same cycle the operands are applied. The flag register is the only state. A wrong capture or enable shows on the flag pins one edge after the operation, or as a flag that changes during an idle cycle. Every legal amount in both directions is swept for several operand patterns against a bit-serial model. This brings out any off-by-one in the index of the lost bit or in a clamp limit at the exact boundary.

// File: rtl/gbit_shifter.sv
module gbit_shifter #(
  parameter int WIDTH     = 40,
  parameter int GUARD     = 8,
  parameter int AMT_W     = 7,
  parameter int AMT_LSB   = 16,
  parameter int ARITH_MAX = 32,
  parameter int LOGIC_MAX = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic                    op_logical,
  input  logic                    use_imm,
  input  logic signed [AMT_W-1:0] imm,
  input  logic [WIDTH-1:0]        src_a,
  input  logic                    src_guard,
  input  logic [WIDTH-GUARD-1:0]  src_b,
  output logic [WIDTH-1:0]        res_full,
  output logic [WIDTH-GUARD-1:0]  res_trunc,
  output logic                    flag_gt,
  output logic                    flag_z,
  output logic                    flag_n,
  output logic                    flag_v,
  output logic                    flag_dc
);
  localparam int BASE = WIDTH - GUARD;
  localparam int HALF = BASE / 2;

  logic signed [AMT_W-1:0] amt_raw, limit, amt_c;
  logic [AMT_W-1:0]        mag;
  logic                    left;
  logic [WIDTH-1:0]        x;

  assign amt_raw = use_imm ? imm : $signed(src_b[AMT_LSB +: AMT_W]);
  assign limit   = op_logical ? AMT_W'(LOGIC_MAX) : AMT_W'(ARITH_MAX);

  always_comb begin
    if (amt_raw > limit)       amt_c = limit;
    else if (amt_raw < -limit) amt_c = -limit;
    else                       amt_c = amt_raw;
  end

  assign left = ~amt_c[AMT_W-1];
  assign mag  = left ? amt_c : -amt_c;
  assign x    = src_guard ? src_a : {{GUARD{src_a[BASE-1]}}, src_a[BASE-1:0]};

  // arithmetic path, with one spare bit to catch the last bit lost
  logic [WIDTH:0]   a_lx, a_rx;
  logic [WIDTH-1:0] a_res;
  logic             a_dc;
  assign a_lx  = {1'b0, x} << mag;
  assign a_rx  = {x, 1'b0} >> mag;
  assign a_res = left ? a_lx[WIDTH-1:0] : WIDTH'($signed(x) >>> mag);
  assign a_dc  = left ? a_lx[WIDTH] : a_rx[0];

  // logical path on the upper half of the base word
  logic [HALF:0]   l_lx, l_rx;
  logic [HALF-1:0] l_res;
  logic            l_dc;
  assign l_lx  = {1'b0, x[BASE-1:HALF]} << mag;
  assign l_rx  = {x[BASE-1:HALF], 1'b0} >> mag;
  assign l_res = left ? l_lx[HALF-1:0] : l_rx[HALF:1];
  assign l_dc  = left ? l_lx[HALF] : l_rx[0];

  assign res_full  = op_logical ? {{GUARD{1'b0}}, l_res, {HALF{1'b0}}} : a_res;
  assign res_trunc = res_full[BASE-1:0];

  logic z_n, v_n;
  assign z_n = (res_full == '0);
  assign v_n = ~op_logical & left & (a_res[WIDTH-1] ^ x[WIDTH-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_gt <= 1'b0;
      flag_z  <= 1'b0;
      flag_n  <= 1'b0;
      flag_v  <= 1'b0;
      flag_dc <= 1'b0;
    end else if (valid) begin
      flag_gt <= ~z_n & ~res_full[WIDTH-1];
      flag_z  <= z_n;
      flag_n  <= res_full[WIDTH-1];
      flag_v  <= v_n;
      flag_dc <= op_logical ? l_dc : a_dc;
    end
  end
endmodule

// File: rtl/gbit_shifter_chk.sv
module gbit_shifter_chk #(
  parameter int WIDTH = 40,
  parameter int GUARD = 8,
  parameter int AMT_W = 7,
  parameter int HALF  = (WIDTH - GUARD) / 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    valid,
  input logic                    op_logical,
  input logic                    use_imm,
  input logic signed [AMT_W-1:0] imm,
  input logic [WIDTH-1:0]        res_full,
  input logic                    flag_gt,
  input logic                    flag_z,
  input logic                    flag_n,
  input logic                    flag_v,
  input logic                    flag_dc
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable({flag_gt, flag_z, flag_n, flag_v, flag_dc}));   // R11
  AST_Z_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> flag_z == ($past(res_full) == '0));                       // R8
  AST_N_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> flag_n == $past(res_full[WIDTH-1]));                       // R8
  AST_GT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_gt && (flag_z || flag_n)));                                   // R8
  AST_LOGIC_NO_V: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op_logical |=> !flag_v);                                    // R9
  AST_ZERO_AMT_DC: assert property (@(posedge clk) disable iff (!rst_n)
    valid && use_imm && imm == '0 |=> !flag_dc);                         // R10
  AST_LOGIC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    op_logical |-> res_full[WIDTH-1:WIDTH-GUARD] == '0 && res_full[HALF-1:0] == '0); // R5
endmodule

bind gbit_shifter gbit_shifter_chk #(.WIDTH(WIDTH), .GUARD(GUARD), .AMT_W(AMT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .op_logical(op_logical), .use_imm(use_imm),
  .imm(imm), .res_full(res_full), .flag_gt(flag_gt), .flag_z(flag_z), .flag_n(flag_n),
  .flag_v(flag_v), .flag_dc(flag_dc));

// File: tb/gbit_shifter_bench.sv
module gbit_shifter_bench;
  logic clk = 0, rst_n = 0, valid = 0, op_logical = 0, use_imm = 0, src_guard = 1;
  logic signed [6:0] imm = '0;
  logic [39:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [39:0] res_full;
  logic [31:0] res_trunc;
  logic flag_gt, flag_z, flag_n, flag_v, flag_dc;

  always #2.5 clk = ~clk;

  gbit_shifter u_gbit_shifter (.*);

  typedef struct { logic [39:0] res; logic [4:0] flg; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  logic [4:0] last_flg = '0;
  bit done = 0;

  function automatic item_t model(logic lg, logic ui, logic signed [6:0] im,
                                  logic [39:0] a, logic g, logic [31:0] b);
    item_t it;
    int amt, lim, n;
    logic [39:0] x, v;
    logic [15:0] u;
    logic dc, vf, z;
    amt = ui ? int'(im) : int'($signed(b[22:16]));
    lim = lg ? 16 : 32;
    if (amt > lim) amt = lim;
    if (amt < -lim) amt = -lim;
    n = (amt < 0) ? -amt : amt;
    x = g ? a : {{8{a[31]}}, a[31:0]};
    v = x; dc = 0; u = x[31:16];
    for (int i = 0; i < n; i++) begin
      if (!lg && amt >= 0) begin dc = v[39]; v = {v[38:0], 1'b0}; end
      else if (!lg)        begin dc = v[0];  v = {v[39], v[39:1]}; end
      else if (amt >= 0)   begin dc = u[15]; u = {u[14:0], 1'b0}; end
      else                 begin dc = u[0];  u = {1'b0, u[15:1]}; end
    end
    if (lg) v = {8'h00, u, 16'h0000};
    vf = !lg && amt > 0 && (v[39] != x[39]);
    z = (v == '0);
    it.res = v;
    it.flg = {!z && !v[39], z, v[39], vf, dc};
    it.tag = "";
    return it;
  endfunction

  task automatic drive(logic lg, logic ui, logic signed [6:0] im, logic [39:0] a,
                       logic g, logic [31:0] b, logic vld, string tag);
    item_t it;
    @(negedge clk);
    op_logical = lg; use_imm = ui; imm = im; src_a = a; src_guard = g; src_b = b; valid = vld;
    it = model(lg, ui, im, a, g, b);
    if (vld) last_flg = it.flg; else it.flg = last_flg;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        check({it.tag, " result"}, 64'(res_full), 64'(it.res));
        check("R7 truncation", 64'(res_trunc), 64'(it.res[31:0]));
        check({it.tag, " flags"}, 64'({flag_gt, flag_z, flag_n, flag_v, flag_dc}), 64'(it.flg));
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [39:0] pats [5] = '{40'h00_8000_0001, 40'hFF_F0F0_1234, 40'h7F_FFFF_FFFF,
                            40'h00_0000_0000, 40'h12_3456_789A};

  initial begin : driver
    repeat (3) @(posedge clk); #1;
    check("R11 reset flags", 64'({flag_gt, flag_z, flag_n, flag_v, flag_dc}), 64'(0));
    @(negedge clk); rst_n = 1;
    // R2 R3 R10 R9: arithmetic immediate sweep
    foreach (pats[p]) for (int s = -32; s <= 32; s++)
      drive(0, 1, 7'(s), pats[p], 1, 32'h0, 1, "R2 R3 R9 R10 arith");
    // R5: logical sweep
    foreach (pats[p]) for (int s = -16; s <= 16; s++)
      drive(1, 1, 7'(s), pats[p], 1, 32'h0, 1, "R5 logical");
    // R1: register amount with noise outside bits 22..16
    for (int s = -40; s <= 40; s += 7)
      drive(0, 0, 7'sd5, 40'hC3_A5A5_0F0F, 1, 32'hFF80_FFFF | (32'(7'(s)) << 16), 1, "R1 reg amount");
    drive(1, 0, 7'sd0, 40'h00_ABCD_0000, 1, 32'h0083_0000, 1, "R1 reg logical");
    // R4: guard bits replaced by sign of bit 31
    drive(0, 1, -7'sd4, 40'h00_8000_0000, 0, 32'h0, 1, "R4 extend neg");
    drive(0, 1, 7'sd1,  40'hFF_4000_0000, 0, 32'h0, 1, "R4 extend pos");
    drive(0, 1, 7'sd0,  40'h5A_8000_0010, 0, 32'h0, 1, "R4 extend zero");
    // R6: clamping
    drive(0, 1, 7'sd40,  40'h00_0000_0003, 1, 32'h0, 1, "R6 clamp arith hi");
    drive(0, 1, -7'sd50, 40'h80_0000_0000, 1, 32'h0, 1, "R6 clamp arith lo");
    drive(1, 1, 7'sd20,  40'h00_8001_0000, 1, 32'h0, 1, "R6 clamp logic hi");
    drive(1, 1, -7'sd64, 40'h00_8001_0000, 1, 32'h0, 1, "R6 clamp logic lo");
    drive(0, 0, 7'sd0,   40'h00_0000_0001, 1, 32'h003F_0000, 1, "R6 clamp reg");
    // R9: sign change on left shift
    drive(0, 1, 7'sd1, 40'h40_0000_0000, 1, 32'h0, 1, "R9 overflow");
    drive(0, 1, 7'sd1, 40'hC0_0000_0000, 1, 32'h0, 1, "R9 no overflow");
    // R11: idle cycles keep flags, R10 sets dc before idle
    drive(0, 1, -7'sd1, 40'h00_0000_0001, 1, 32'h0, 1, "R10 dc set");
    drive(0, 1, 7'sd0,  40'h00_0000_0000, 1, 32'h0, 0, "R11 hold idle");
    drive(1, 1, 7'sd3,  40'hFF_FFFF_FFFF, 1, 32'h0, 0, "R11 hold idle2");
    drive(0, 1, 7'sd0,  40'h00_0000_0000, 1, 32'h0, 1, "R8 zero result");
    @(negedge clk); valid = 0;
    repeat (4) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule